// File: doc/BRIEF.md
# Sector Lock and Identification Unit

This block holds the write-protection state of a byte-wide flash array split into 32 equal sectors of 64 KB, and answers the identification reads that let a host learn who made the part, which part it is, and whether a given sector is locked. The cell array, charge pumps and analog voltage sensing live elsewhere. The elevated-voltage condition on the part's reset pin arrives here as a plain digital flag, `hv_unlock_i`.

The host locks a sector by raising `lock_req_i` while the flag is high and the address carries the protect pattern in bits 6, 1 and 0. A separate pattern releases every lock at once, but only after all sectors have been locked. Program and erase requests from the write engine are checked against the lock bits. Each request returns a one-cycle accept pulse or a one-cycle reject pulse. While the flag is high, every lock is bypassed without being forgotten. Identification reads return a code one cycle after the strobe.

All outputs are registered. A request is always judged against the lock bits as they stood before the clock edge that samples it. The model's own synchronous reset clears every lock.

Top module: `sect_guard_top`

## Requirements
- R1: The sector index is address bits 20 down to 16. Sector n spans byte addresses n*0x10000 through n*0x10000+0xFFFF, and the low 16 bits never change which sector is addressed.
- R2: With `id_mode_i` high, a read strobe `rd_i` yields `rvalid_o`=1 one cycle later. The data is 0x01 when address bits {6,1,0}=000 and 0xC8 when they are 001. When no identification read was taken, `rvalid_o` and `rdata_o` are 0 in the following cycle.
- R3: An identification read with bits {6,1,0}=010 returns 0x01 if the stored lock bit of the addressed sector is set and 0x00 if it is clear, whatever the state of `hv_unlock_i`. Any {6,1,0} pattern other than 000, 001 and 010 reads 0x00.
- R4: `lock_req_i` with `hv_unlock_i`=1 and bits {6,1,0}=010 sets the lock bit of the addressed sector. A lock request with `hv_unlock_i`=0, or with any other pattern apart from 110, changes no lock bit.
- R5: `lock_req_i` with `hv_unlock_i`=1 and bits {6,1,0}=110 clears all 32 lock bits, but only if all 32 are set. Otherwise it has no effect.
- R6: A program (`pgm_req_i`) or erase (`ers_req_i`) request to a locked sector while `hv_unlock_i`=0 gives a reject pulse one cycle later. Any other request gives an accept pulse. Exactly one of the two pulses follows each request, and neither appears without one.
- R7: While `hv_unlock_i`=1, program and erase requests to locked sectors are accepted. When the flag falls, the stored lock bits are unchanged and rejection resumes.
- R8: `rst_n` low at a clock edge clears every lock bit and drives every output to 0.
- R9: A read or request sampled at the same edge as a lock change sees the lock bits from before that change. The change is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the model |
| hv_unlock_i | input | 1 | Elevated-voltage-on-reset flag: enables lock changes and bypasses locks |
| id_mode_i | input | 1 | Identification read mode is active |
| addr_i | input | 21 | Byte address; bits 20:16 select the sector, bits 6, 1, 0 select the code or operation |
| rd_i | input | 1 | Identification read strobe |
| lock_req_i | input | 1 | Protect or unprotect write strobe |
| pgm_req_i | input | 1 | Program request to the addressed sector |
| ers_req_i | input | 1 | Erase request to the addressed sector |
| rdata_o | output | 8 | Identification code |
| rvalid_o | output | 1 | Identification code valid |
| pgm_ok_o | output | 1 | Program request accepted (one-cycle pulse) |
| pgm_rej_o | output | 1 | Program request rejected (one-cycle pulse) |
| ers_ok_o | output | 1 | Erase request accepted (one-cycle pulse) |
| ers_rej_o | output | 1 | Erase request rejected (one-cycle pulse) |

## Verification
A lock write and an identification read can land on the same sector in the same cycle, because both share the address bus and the {6,1,0}=010 pattern. The bench raises `lock_req_i` and `rd_i` together on an unlocked sector and expects the read to return the old code 0x00. It then expects a program request to that sector in the following cycle, with the flag low, to be rejected. A second collision drives program and erase to one locked sector at once and expects both reject pulses together.

// File: rtl/sg_pkg.sv
package sg_pkg;

    // Decoded meaning of address control bits 6, 1 and 0.
    typedef enum logic [2:0] {
        SEL_MFR    = 3'd0,  // {6,1,0} = 000
        SEL_DEV    = 3'd1,  // {6,1,0} = 001
        SEL_SECT   = 3'd2,  // {6,1,0} = 010 : lock query / lock set
        SEL_UNPROT = 3'd3,  // {6,1,0} = 110 : release all
        SEL_OTHER  = 3'd4
    } sel_e;

    function automatic sel_e sel_decode(input logic b6, input logic b1, input logic b0);
        sel_e r;
        case ({b6, b1, b0})
            3'b000:  r = SEL_MFR;
            3'b001:  r = SEL_DEV;
            3'b010:  r = SEL_SECT;
            3'b110:  r = SEL_UNPROT;
            default: r = SEL_OTHER;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sg_lock_bank.sv
module sg_lock_bank #(
    parameter int unsigned SECT_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hv_i,
    input  logic                     req_i,
    input  sg_pkg::sel_e             sel_i,
    input  logic [SECT_W-1:0]        sect_i,
    output logic [(1<<SECT_W)-1:0]   lock_o
);
    localparam int unsigned NSECT = 1 << SECT_W;

    typedef struct packed {
        logic [NSECT-1:0] bits;
    } lk_s;

    lk_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_i && hv_i) begin
            case (sel_i)
                sg_pkg::SEL_SECT:   st_d.bits[sect_i] = 1'b1;
                sg_pkg::SEL_UNPROT: if (&st_q.bits) st_d.bits = '0;
                default:            ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.bits;

    AST_LOCK_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_i |=> $stable(lock_o)); // R4
    AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(lock_o)); // R4
    AST_LOCK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ($countones(lock_o & ~$past(lock_o)) <= 1)); // R4
    AST_UNPROT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o != {NSECT{1'b1}}) |=> ((lock_o & $past(lock_o)) == $past(lock_o))); // R5

endmodule

// File: rtl/sg_pe_gate.sv
module sg_pe_gate #(
    parameter int unsigned SECT_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hv_i,
    input  logic                     req_i,
    input  logic [SECT_W-1:0]        sect_i,
    input  logic [(1<<SECT_W)-1:0]   lock_i,
    output logic                     ok_o,
    output logic                     rej_o
);
    typedef struct packed {
        logic ok;
        logic rej;
    } gt_s;

    gt_s  st_d, st_q;
    logic blocked;

    always_comb begin
        blocked = lock_i[sect_i] && !hv_i;
        st_d.ok  = req_i && !blocked;
        st_d.rej = req_i &&  blocked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok_o  = st_q.ok;
    assign rej_o = st_q.rej;

    AST_GATE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ($countones({ok_o, rej_o}) == 1)); // R6
    AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!ok_o && !rej_o)); // R6
    AST_GATE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !hv_i && lock_i[sect_i]) |=> rej_o); // R6
    AST_GATE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && hv_i) |=> ok_o); // R7

endmodule

// File: rtl/sg_ident.sv
module sg_ident #(
    parameter int unsigned SECT_W   = 5,
    parameter logic [7:0]  MFR_CODE = 8'h01,
    parameter logic [7:0]  DEV_CODE = 8'hC8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_i,
    input  logic                     mode_i,
    input  sg_pkg::sel_e             sel_i,
    input  logic [SECT_W-1:0]        sect_i,
    input  logic [(1<<SECT_W)-1:0]   lock_i,
    output logic [7:0]               rdata_o,
    output logic                     rvalid_o
);
    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } id_s;

    id_s st_d, st_q;

    always_comb begin
        st_d.valid = rd_i && mode_i;
        st_d.data  = 8'h00;
        if (st_d.valid) begin
            case (sel_i)
                sg_pkg::SEL_MFR:  st_d.data = MFR_CODE;
                sg_pkg::SEL_DEV:  st_d.data = DEV_CODE;
                sg_pkg::SEL_SECT: st_d.data = {7'd0, lock_i[sect_i]};
                default:          st_d.data = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o  = st_q.data;
    assign rvalid_o = st_q.valid;

    AST_ID_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_i) |=> rvalid_o); // R2
    AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && mode_i) |=> (!rvalid_o && rdata_o == 8'h00)); // R2
    AST_ID_SECT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && mode_i && sel_i == sg_pkg::SEL_SECT) |=> (rdata_o[7:1] == 7'd0)); // R3

endmodule

// File: rtl/sect_guard_top.sv
module sect_guard_top #(
    parameter int unsigned ADDR_W   = 21,
    parameter int unsigned SECT_W   = 5,
    parameter logic [7:0]  MFR_CODE = 8'h01,
    parameter logic [7:0]  DEV_CODE = 8'hC8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_unlock_i,
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              lock_req_i,
    input  logic              pgm_req_i,
    input  logic              ers_req_i,
    output logic [7:0]        rdata_o,
    output logic              rvalid_o,
    output logic              pgm_ok_o,
    output logic              pgm_rej_o,
    output logic              ers_ok_o,
    output logic              ers_rej_o
);
    localparam int unsigned NSECT    = 1 << SECT_W;
    localparam int unsigned SECT_LSB = ADDR_W - SECT_W;
    localparam int unsigned NCHAN    = 2;  // 0: program, 1: erase

    logic [SECT_W-1:0] sect;
    sg_pkg::sel_e      sel;
    logic [NSECT-1:0]  lock_vec;
    logic [NCHAN-1:0]  chan_req, chan_ok, chan_rej;
    logic              unused_addr;

    // R1: sector index from the top address bits
    assign sect        = addr_i[ADDR_W-1:SECT_LSB];
    assign sel         = sg_pkg::sel_decode(addr_i[6], addr_i[1], addr_i[0]);
    assign unused_addr = ^{addr_i[SECT_LSB-1:7], addr_i[5:2]};

    sg_lock_bank #(.SECT_W(SECT_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .hv_i   (hv_unlock_i),
        .req_i  (lock_req_i),
        .sel_i  (sel),
        .sect_i (sect),
        .lock_o (lock_vec)
    );

    sg_ident #(.SECT_W(SECT_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_ident (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_i),
        .mode_i   (id_mode_i),
        .sel_i    (sel),
        .sect_i   (sect),
        .lock_i   (lock_vec),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    assign chan_req = {ers_req_i, pgm_req_i};

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        sg_pe_gate #(.SECT_W(SECT_W)) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .hv_i   (hv_unlock_i),
            .req_i  (chan_req[g]),
            .sect_i (sect),
            .lock_i (lock_vec),
            .ok_o   (chan_ok[g]),
            .rej_o  (chan_rej[g])
        );
    end

    assign pgm_ok_o  = chan_ok[0];
    assign pgm_rej_o = chan_rej[0];
    assign ers_ok_o  = chan_ok[1];
    assign ers_rej_o = chan_rej[1];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (lock_vec == '0 && !rvalid_o && !pgm_ok_o && !pgm_rej_o
                    && !ers_ok_o && !ers_rej_o)); // R8

endmodule

// File: tb/sect_guard_top_bench.sv
module sect_guard_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;
    // Vector fields: [18:17] op (0 read, 1 program, 2 erase, 3 lock), [16] flag,
    // [15:11] sector, [10:8] address bits {6,1,0}, [7:0] expected (read code, or 1 = reject)
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 5'd0, 3'b000, 8'h01},  // R2 manufacturer code
        {2'd0, 1'b0, 5'd0, 3'b001, 8'hC8},  // R2 device code
        {2'd0, 1'b0, 5'd3, 3'b010, 8'h00},  // R3 unlocked sector
        {2'd1, 1'b0, 5'd3, 3'b000, 8'h00},  // R6 program accepted
        {2'd3, 1'b0, 5'd3, 3'b010, 8'h00},  // R4 lock without flag
        {2'd0, 1'b0, 5'd3, 3'b010, 8'h00},  // R4 still unlocked
        {2'd3, 1'b1, 5'd3, 3'b010, 8'h00},  // R4 lock sector 3
        {2'd0, 1'b0, 5'd3, 3'b010, 8'h01},  // R4 now locked
        {2'd1, 1'b0, 5'd3, 3'b000, 8'h01},  // R6 program rejected
        {2'd2, 1'b0, 5'd3, 3'b000, 8'h01},  // R6 erase rejected
        {2'd2, 1'b0, 5'd4, 3'b000, 8'h00},  // R6 neighbour erase accepted
        {2'd1, 1'b1, 5'd3, 3'b000, 8'h00},  // R7 program bypass
        {2'd2, 1'b1, 5'd3, 3'b000, 8'h00},  // R7 erase bypass
        {2'd0, 1'b1, 5'd3, 3'b010, 8'h01},  // R3 stored bit under flag
        {2'd1, 1'b0, 5'd3, 3'b000, 8'h01},  // R7 rejection resumes
        {2'd3, 1'b1, 5'd3, 3'b110, 8'h00},  // R5 release while not full
        {2'd0, 1'b0, 5'd3, 3'b010, 8'h01},  // R5 lock kept
        {2'd3, 1'b1, 5'd5, 3'b000, 8'h00},  // R4 wrong pattern
        {2'd0, 1'b0, 5'd5, 3'b010, 8'h00},  // R4 sector 5 unlocked
        {2'd0, 1'b0, 5'd3, 3'b110, 8'h00}   // R3 other pattern reads zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv = 1'b0;
    logic        id_mode = 1'b1;
    logic [20:0] addr = '0;
    logic        rd = 1'b0, lock_req = 1'b0, pgm_req = 1'b0, ers_req = 1'b0;
    logic [7:0]  rdata;
    logic        rvalid, pgm_ok, pgm_rej, ers_ok, ers_rej;
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sect_guard_top u_sect_guard_top (
        .clk(clk), .rst_n(rst_n), .hv_unlock_i(hv), .id_mode_i(id_mode), .addr_i(addr),
        .rd_i(rd), .lock_req_i(lock_req), .pgm_req_i(pgm_req), .ers_req_i(ers_req),
        .rdata_o(rdata), .rvalid_o(rvalid), .pgm_ok_o(pgm_ok), .pgm_rej_o(pgm_rej),
        .ers_ok_o(ers_ok), .ers_rej_o(ers_rej)
    );

    function automatic logic [20:0] mk(input logic [4:0] s, input logic [2:0] c);
        return {s, 9'd0, c[2], 4'd0, c[1], c[0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request cycle; outputs for it are valid on return.
    task automatic step(input logic lk, input logic pg, input logic er, input logic rq,
                        input logic f, input logic [20:0] a);
        @(negedge clk);
        lock_req = lk; pgm_req = pg; ers_req = er; rd = rq; hv = f; addr = a;
        @(negedge clk);
        lock_req = 1'b0; pgm_req = 1'b0; ers_req = 1'b0; rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] s, input logic [7:0] code);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, mk(s, 3'b010));
        chk(tag, {7'd0, rvalid, rdata}, {7'd0, 1'b1, code});
    endtask

    function automatic logic [15:0] outs();
        return {8'd0, rvalid, pgm_ok, pgm_rej, ers_ok, ers_rej, 3'd0} | {8'd0, rdata};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset outputs", outs(), 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            logic [18:0] v;
            logic [1:0]  op;
            v  = VEC[i];
            op = v[18:17];
            step(op == 2'd3, op == 2'd1, op == 2'd2, op == 2'd0, v[16], mk(v[15:11], v[10:8]));
            case (op)
                2'd0: chk((v[10:8] == 3'b010) ? "R3 lock code" : "R2 id code",
                          {7'd0, rvalid, rdata}, {7'd0, 1'b1, v[7:0]});
                2'd1: chk(v[16] ? "R7 program" : "R6 program",
                          {14'd0, pgm_ok, pgm_rej}, v[0] ? 16'd1 : 16'd2);
                2'd2: chk(v[16] ? "R7 erase" : "R6 erase",
                          {14'd0, ers_ok, ers_rej}, v[0] ? 16'd1 : 16'd2);
                default: ;
            endcase
        end

        // R2: read outside identification mode gives nothing
        id_mode = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, mk(5'd0, 3'b000));
        chk("R2 mode off", {7'd0, rvalid, rdata}, 16'h0000);
        id_mode = 1'b1;

        // R1: sector 3 is locked; decode uses bits 20:16 only
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 21'h03FFFF);
        chk("R1 top of sector 3", {14'd0, pgm_ok, pgm_rej}, 16'd1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 21'h040000);
        chk("R1 base of sector 4", {14'd0, pgm_ok, pgm_rej}, 16'd2);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 21'h02FFFF);
        chk("R1 top of sector 2", {14'd0, pgm_ok, pgm_rej}, 16'd2);

        // R9: lock and read of sector 7 in the same cycle
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, mk(5'd7, 3'b010));
        chk("R9 read sees old bit", {7'd0, rvalid, rdata}, 16'h0100);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, mk(5'd7, 3'b000));
        chk("R9 next-cycle program", {14'd0, pgm_ok, pgm_rej}, 16'd1);
        // R6: program and erase together on a locked sector
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, mk(5'd7, 3'b000));
        chk("R6 dual request", {12'd0, pgm_ok, pgm_rej, ers_ok, ers_rej}, 16'b0101);

        // R5: lock every sector, then release all
        for (int s = 0; s < 32; s++)
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, mk(s[4:0], 3'b010));
        rd_chk("R5 all locked", 5'd31, 8'h01);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, mk(5'd0, 3'b110));
        rd_chk("R5 released s0", 5'd0, 8'h00);
        rd_chk("R5 released s17", 5'd17, 8'h00);
        rd_chk("R5 released s31", 5'd31, 8'h00);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, mk(5'd17, 3'b000));
        chk("R5 program after release", {14'd0, pgm_ok, pgm_rej}, 16'd2);

        // R8: reset mid-run clears locks
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, mk(5'd9, 3'b010));
        rd_chk("R8 locked before reset", 5'd9, 8'h01);
        @(negedge clk); rst_n = 1'b0; hv = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 outputs after reset", outs(), 16'h0000);
        rd_chk("R8 lock cleared", 5'd9, 8'h00);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, mk(5'd9, 3'b000));
        chk("R8 erase after reset", {14'd0, ers_ok, ers_rej}, 16'd2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule